// File: doc/BRIEF.md
# Serial Poll Status Byte Sequencer

This block supplies the status bytes that a bus controller reads back while it holds the device in serial poll. When poll mode begins, the block presents a byte that holds the latched X and Q crate response. Four further bytes follow, each packing six slot interrupt-request bits, starting at slot 1. One byte is on offer at a time. The bus data path takes it, and a one-cycle byte-accepted strobe moves the sequencer on. The service-request (SRQ) flag belongs to the block. Its current value always sits in the top bit of the byte on offer. The flag clears when the fifth byte is accepted, or earlier when a poll-disable command arrives. While poll mode is active, the block holds the normal data and crate-cycle path inhibited.

The sequencer has four states. IDLE means no poll is in progress. XQ presents the response byte. SLOT presents a slot byte, and a group counter picks which one. DONE means every byte has been read. The transitions are as follows. Enter goes from IDLE to XQ on a rising edge of the poll-mode input. First-accept goes from XQ to SLOT with the group set to 0. Next-group stays in SLOT and adds one to the group when a byte is accepted. Last-accept goes from SLOT to DONE when the final group is accepted. Leave goes from any state to IDLE when poll mode drops. Disable goes from any state to IDLE on a poll-disable command. While in DONE, accepts are ignored and the state holds.

Top module: `spoll_status_seq`

## Requirements
- R1: After reset, byte_valid, srq and xfer_inhibit are all 0.
- R2: Whenever byte_valid is 1, bit 7 of status_byte equals the srq output and bit 0 is 0.
- R3: The first byte after poll entry carries x_resp in bit 1 and q_resp in bit 2, with bits 3 to 6 at 0.
- R4: Byte k, for k from 1 to 4, carries lam[6(k-1)+5 : 6(k-1)] in bits 6 to 1. lam bit 0 is slot 1, so the lowest slot of each group lands in bit 1.
- R5: A byte_ack while byte_valid is 1 moves to the next byte in the following cycle. After the fifth byte is accepted, byte_valid is 0 and status_byte is 0x00, and further acks change nothing until poll_active drops.
- R6: A srq_raise pulse sets srq in the next cycle. srq clears in the cycle after the fifth byte is accepted.
- R7: A poll_disable pulse clears srq and drops byte_valid in the next cycle, even partway through the sequence. The block stays idle until poll_active rises again.
- R8: Every rising edge of poll_active, when no poll_disable comes with it, restarts the sequence at the first byte, including after a sequence that was left unfinished.
- R9: xfer_inhibit is 1 in every cycle where poll_active is 1, and also while the sequencer is not IDLE.
- R10: srq_raise in the same cycle as a clearing event (last accept or poll_disable) leaves srq at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_active | input | 1 | Serial poll mode is active |
| poll_disable | input | 1 | One-cycle poll-disable command strobe |
| byte_ack | input | 1 | One-cycle strobe: the byte on offer was accepted |
| srq_raise | input | 1 | One-cycle request to set the service request |
| x_resp | input | 1 | Latched X response |
| q_resp | input | 1 | Latched Q response |
| lam | input | 24 | Per-slot interrupt requests, bit 0 = slot 1 |
| status_byte | output | 8 | Status byte on offer |
| byte_valid | output | 1 | status_byte holds a byte of the sequence |
| srq | output | 1 | Service request flag |
| xfer_inhibit | output | 1 | Normal transfers and crate cycles are held off |

## Verification
Full five-byte reads run with SRQ set and with SRQ clear, and with different X/Q values and interrupt patterns. These show whether the top bit follows the live flag and whether X and Q sit in their proper places. One interrupt pattern sets a single bit in each group, another sets the edge slots 1 and 24, and a third sets mixed bits. Between them they catch a wrong group order, a shifted payload or reversed bits inside a byte. Partial reads are stopped by poll-disable, and others are left by dropping poll mode and entering again. These separate correct restart and flag clearing from a counter that keeps stale progress. Raise requests that land on the same cycle as each clearing event show which of the two wins.

// File: rtl/spoll_pkg.sv
package spoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XQ,
        ST_SLOT,
        ST_DONE
    } spoll_state_e;

endpackage

// File: rtl/spoll_seq_fsm.sv
module spoll_seq_fsm
    import spoll_pkg::*;
#(
    parameter int SLOT_BYTES = 4,
    parameter int GRP_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_active,
    input  logic             poll_disable,
    input  logic             byte_ack,
    output logic [GRP_W-1:0] grp,
    output logic             sel_xq,
    output logic             byte_valid,
    output logic             busy,
    output logic             last_accept
);

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(SLOT_BYTES - 1);

    spoll_state_e     state_q, state_d;
    logic [GRP_W-1:0] grp_q, grp_d;
    logic             poll_q;
    logic             enter;

    assign enter = poll_active && !poll_q;

    // next-state and group selection
    always_comb begin
        state_d = state_q;
        grp_d   = grp_q;
        if (!poll_active || poll_disable) begin
            state_d = ST_IDLE;              // leave / disable
        end else begin
            unique case (state_q)
                ST_IDLE: if (enter) begin   // enter
                    state_d = ST_XQ;
                    grp_d   = '0;
                end
                ST_XQ: if (byte_ack) begin  // first-accept
                    state_d = ST_SLOT;
                    grp_d   = '0;
                end
                ST_SLOT: if (byte_ack) begin
                    if (grp_q == LAST_GRP) begin
                        state_d = ST_DONE;  // last-accept
                    end else begin
                        grp_d = grp_q + 1'b1; // next-group
                    end
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            poll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
            poll_q  <= poll_active;
        end
    end

    // outputs
    always_comb begin
        sel_xq      = 1'b0;
        byte_valid  = 1'b0;
        busy        = 1'b1;
        last_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_XQ: begin
                sel_xq     = 1'b1;
                byte_valid = 1'b1;
            end
            ST_SLOT: begin
                byte_valid  = 1'b1;
                last_accept = byte_ack && poll_active && !poll_disable &&
                              (grp_q == LAST_GRP);
            end
            ST_DONE: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign grp = grp_q;

endmodule

// File: rtl/spoll_byte_fmt.sv
module spoll_byte_fmt #(
    parameter int SLOT_BYTES     = 4,
    parameter int SLOTS_PER_BYTE = 6,
    parameter int GRP_W          = 2,
    parameter int LAM_W          = SLOT_BYTES * SLOTS_PER_BYTE
) (
    input  logic             srq,
    input  logic             x_resp,
    input  logic             q_resp,
    input  logic [LAM_W-1:0] lam,
    input  logic             sel_xq,
    input  logic             byte_valid,
    input  logic [GRP_W-1:0] grp,
    output logic [7:0]       status_byte
);

    logic [7:0] grp_byte [SLOT_BYTES];

    // one candidate byte per slot group: lowest slot in bit 1
    for (genvar g = 0; g < SLOT_BYTES; g++) begin : g_grp
        logic [5:0] payload;
        assign payload     = 6'(lam[g*SLOTS_PER_BYTE +: SLOTS_PER_BYTE]);
        assign grp_byte[g] = {srq, payload, 1'b0};
    end

    always_comb begin
        if (!byte_valid) begin
            status_byte = 8'h00;
        end else if (sel_xq) begin
            status_byte = {srq, 4'b0000, q_resp, x_resp, 1'b0};
        end else begin
            status_byte = grp_byte[grp];
        end
    end

endmodule

// File: rtl/spoll_srq_flag.sv
module spoll_srq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    output logic srq
);

    // a new request outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srq <= 1'b0;
        end else if (raise) begin
            srq <= 1'b1;
        end else if (clear) begin
            srq <= 1'b0;
        end
    end

endmodule

// File: rtl/spoll_status_seq.sv
module spoll_status_seq #(
    parameter int SLOT_BYTES     = 4,
    parameter int SLOTS_PER_BYTE = 6,
    localparam int LAM_W         = SLOT_BYTES * SLOTS_PER_BYTE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_active,
    input  logic             poll_disable,
    input  logic             byte_ack,
    input  logic             srq_raise,
    input  logic             x_resp,
    input  logic             q_resp,
    input  logic [LAM_W-1:0] lam,
    output logic [7:0]       status_byte,
    output logic             byte_valid,
    output logic             srq,
    output logic             xfer_inhibit
);

    localparam int GRP_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;

    logic [GRP_W-1:0] grp;
    logic             sel_xq;
    logic             busy;
    logic             last_accept;

    spoll_seq_fsm #(
        .SLOT_BYTES (SLOT_BYTES),
        .GRP_W      (GRP_W)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .poll_active  (poll_active),
        .poll_disable (poll_disable),
        .byte_ack     (byte_ack),
        .grp          (grp),
        .sel_xq       (sel_xq),
        .byte_valid   (byte_valid),
        .busy         (busy),
        .last_accept  (last_accept)
    );

    spoll_srq_flag i_srq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (srq_raise),
        .clear (last_accept || poll_disable),
        .srq   (srq)
    );

    spoll_byte_fmt #(
        .SLOT_BYTES     (SLOT_BYTES),
        .SLOTS_PER_BYTE (SLOTS_PER_BYTE),
        .GRP_W          (GRP_W)
    ) i_fmt (
        .srq         (srq),
        .x_resp      (x_resp),
        .q_resp      (q_resp),
        .lam         (lam),
        .sel_xq      (sel_xq),
        .byte_valid  (byte_valid),
        .grp         (grp),
        .status_byte (status_byte)
    );

    assign xfer_inhibit = poll_active || busy;

endmodule

// File: rtl/spoll_status_seq_chk.sv
module spoll_status_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_active,
    input logic       poll_disable,
    input logic       srq_raise,
    input logic [7:0] status_byte,
    input logic       byte_valid,
    input logic       srq,
    input logic       xfer_inhibit
);

    // R2
    a_r2_top_bit_is_srq: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (status_byte[7] == srq) && !status_byte[0]);

    // R3
    a_r3_first_byte_pad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> (status_byte[6:3] == 4'b0000));

    // R6
    a_r6_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        srq_raise |=> srq);

    // R7
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_disable && !srq_raise) |=> (!srq && !byte_valid));

    // R8
    a_r8_entry_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(poll_active) && !poll_disable) |=> byte_valid);

    // R9
    a_r9_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        poll_active |-> xfer_inhibit);

endmodule

bind spoll_status_seq spoll_status_seq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .poll_active  (poll_active),
    .poll_disable (poll_disable),
    .srq_raise    (srq_raise),
    .status_byte  (status_byte),
    .byte_valid   (byte_valid),
    .srq          (srq),
    .xfer_inhibit (xfer_inhibit)
);

// File: tb/test_spoll_status_seq.sv
`timescale 1ns/1ps
module test_spoll_status_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_active = 1'b0;
    logic        poll_disable = 1'b0;
    logic        byte_ack = 1'b0;
    logic        srq_raise = 1'b0;
    logic        x_resp = 1'b0;
    logic        q_resp = 1'b0;
    logic [23:0] lam = '0;
    logic [7:0]  status_byte;
    logic        byte_valid;
    logic        srq;
    logic        xfer_inhibit;

    int checks = 0;
    int failures = 0;
    bit srq_model = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    spoll_status_seq i_spoll_status_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .poll_active  (poll_active),
        .poll_disable (poll_disable),
        .byte_ack     (byte_ack),
        .srq_raise    (srq_raise),
        .x_resp       (x_resp),
        .q_resp       (q_resp),
        .lam          (lam),
        .status_byte  (status_byte),
        .byte_valid   (byte_valid),
        .srq          (srq),
        .xfer_inhibit (xfer_inhibit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int idx);
        if (idx == 0) return {srq_model, 4'b0000, q_resp, x_resp, 1'b0};
        return {srq_model, lam[(idx-1)*6 +: 6], 1'b0};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic raise();
        srq_raise = 1'b1;
        step();
        srq_raise = 1'b0;
        srq_model = 1'b1;
    endtask

    task automatic enter();
        poll_active = 1'b1;
        step();
    endtask

    task automatic leave();
        poll_active = 1'b0;
        step();
    endtask

    // driver: push expected byte, then accept it
    task automatic read_byte(input int idx);
        exp_q.push_back(exp_byte(idx));
        tag_q.push_back(idx == 0 ? "R3 R2 byte0" : "R4 R2 slot byte");
        byte_ack = 1'b1;
        step();
        byte_ack = 1'b0;
        if (idx == 4) srq_model = 1'b0;
    endtask

    task automatic read_all();
        for (int i = 0; i < 5; i++) read_byte(i);
    endtask

    // monitor: compare the byte being accepted
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && byte_ack && byte_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected byte", {24'h0, status_byte}, 32'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(status_byte == e, t, {24'h0, status_byte}, {24'h0, e});
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!byte_valid && !srq && !xfer_inhibit, "R1 reset",
            {29'h0, byte_valid, srq, xfer_inhibit}, 32'h0);

        // full read, SRQ set, mixed pattern
        x_resp = 1'b1; q_resp = 1'b0; lam = 24'h9A5CE3;
        raise();
        chk(srq == 1'b1, "R6 raise sets", {31'h0, srq}, 32'h1);
        enter();
        chk(xfer_inhibit && byte_valid, "R9 inhibit on entry",
            {30'h0, xfer_inhibit, byte_valid}, 32'h3);
        read_all();
        chk(!srq && !byte_valid, "R6 R5 cleared after fifth",
            {30'h0, srq, byte_valid}, 32'h0);
        byte_ack = 1'b1; step(); step(); byte_ack = 1'b0;
        chk(!byte_valid && status_byte == 8'h00 && !srq, "R5 acks ignored in done",
            {22'h0, byte_valid, srq, status_byte}, 32'h0);
        chk(xfer_inhibit == 1'b1, "R9 inhibit in done", {31'h0, xfer_inhibit}, 32'h1);
        leave();
        chk(xfer_inhibit == 1'b0, "R9 inhibit released", {31'h0, xfer_inhibit}, 32'h0);

        // SRQ clear, one bit per group
        x_resp = 1'b0; q_resp = 1'b1; lam = 24'h820820;
        enter();
        read_all();
        leave();

        // edge slots 1 and 24
        x_resp = 1'b1; q_resp = 1'b1; lam = 24'h800001;
        enter();
        read_all();
        leave();

        // disable partway through
        lam = 24'h3C3C3C;
        raise();
        enter();
        read_byte(0);
        read_byte(1);
        poll_disable = 1'b1; step(); poll_disable = 1'b0;
        srq_model = 1'b0;
        chk(!srq && !byte_valid, "R7 disable clears",
            {30'h0, srq, byte_valid}, 32'h0);
        byte_ack = 1'b1; step(); byte_ack = 1'b0;
        chk(!byte_valid, "R7 stays idle", {31'h0, byte_valid}, 32'h0);
        leave();

        // leave partway, re-enter restarts
        raise();
        enter();
        read_byte(0); read_byte(1); read_byte(2);
        leave();
        chk(!byte_valid && srq, "R8 left with srq held",
            {30'h0, byte_valid, srq}, 32'h2);
        enter();
        read_all();   // first byte must be X/Q again (R8)

        // raise coincides with last accept
        raise();
        leave();
        enter();
        read_byte(0); read_byte(1); read_byte(2); read_byte(3);
        exp_q.push_back(exp_byte(4));
        tag_q.push_back("R4 R2 last byte");
        byte_ack = 1'b1; srq_raise = 1'b1;
        step();
        byte_ack = 1'b0; srq_raise = 1'b0;
        chk(srq == 1'b1 && !byte_valid, "R10 raise beats last clear",
            {30'h0, srq, byte_valid}, 32'h2);
        poll_disable = 1'b1; srq_raise = 1'b1;
        step();
        poll_disable = 1'b0; srq_raise = 1'b0;
        chk(srq == 1'b1, "R10 raise beats disable", {31'h0, srq}, 32'h1);
        poll_disable = 1'b1; step(); poll_disable = 1'b0;
        chk(srq == 1'b0, "R7 disable alone clears", {31'h0, srq}, 32'h0);
        leave();

        step(); step();
        chk(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule